// File: doc/BRIEF.md
# Legacy Memory Window Router

This block sits in a host bridge and steers every memory access that falls in the legacy window between 0xA0000 and 0xFFFFF. For each access it chooses system DRAM or the expansion bus. The choice depends on the physical address, on whether the access is a read or a write, on the system-management-mode flag, and on a small bank of byte-wide configuration registers. Addresses outside the window always go to DRAM.

The window has three parts. The 128 KB video range (0xA0000 to 0xBFFFF) opens to DRAM under a control byte that can be qualified by system-management mode. Twelve 16 KB expansion segments (0xC0000 to 0xEFFFF) each carry their own two-bit attribute. The 64 KB top range (0xF0000 to 0xFFFFF) carries one further two-bit attribute. A one-byte configuration write port loads the attribute bytes and the control byte on the clock edge. The routing decision itself is combinational, so both a new address and a change of the mode flag act within the same cycle.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset all attribute bytes (offsets 0x59 to 0x5F) are 0x00 and the control byte at offset 0x72 is 0x02. As a result, every access in 0xA0000 to 0xFFFFF goes to the bus, whatever the values of acc_wr and smm_act.
- R2: Any address below 0xA0000 or at or above 0x100000 routes to DRAM, whatever the register contents, acc_wr or smm_act.
- R3: The range 0xF0000 to 0xFFFFF uses the two-bit attribute in bits 5:4 of the byte at offset 0x59.
- R4: Segment k (k = 0 to 11) covers 0xC0000 + k*0x4000 up to 16 KB. It uses the byte at offset 0x5A + k/2: bits 1:0 when k is even and bits 5:4 when k is odd.
- R5: Attribute code 3 sends reads and writes to DRAM. Code 1 sends reads to DRAM and writes to the bus. Codes 0 and 2 send all accesses to the bus.
- R6: The range 0xA0000 to 0xBFFFF routes to DRAM when bit 6 of the byte at 0x72 is set, or when smm_act is high and bit 3 of that byte is set. In every other case it routes to the bus. acc_wr has no effect on this range.
- R7: A change of smm_act changes the routing of the video range in the same cycle, with no clock edge needed.
- R8: A configuration write to offset 0x59 to 0x5F or 0x72 affects routing from the cycle after the capturing edge. A write to any other offset changes no routing.
- R9: route is always one-hot: 2'b10 means DRAM and 2'b01 means the expansion bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_addr | input | ADDR_W | Physical address of the current access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| smm_act | input | 1 | System-management mode is active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration register offset |
| cfg_data | input | 8 | Configuration write data |
| route | output | 2 | Target select: 2'b10 DRAM, 2'b01 bus |

## Verification
Two things can land in the same cycle: a configuration write that is being captured, and an access whose routing depends on the byte being written. The bench places a write and then accesses to the affected segment in the very next cycle. It also toggles smm_act between two back-to-back accesses to the video range. The result is judged against a bench model that updates its register copy only after the capturing edge and treats the mode flag as taking effect at once. Random write and access streams then mix both situations, and each routing result is compared with that model.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [1:0] {
    ROUTE_BUS  = 2'b01,
    ROUTE_DRAM = 2'b10
  } route_e;

  localparam logic [1:0] ATTR_DRAM_RW = 2'b11;
  localparam logic [1:0] ATTR_DRAM_RO = 2'b01;
endpackage

// File: rtl/lmr_rst_sync.sv
module lmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs #(
  parameter int          N_ATTR    = 7,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  CTRL_OFF  = 8'h72,
  parameter logic [7:0]  CTRL_RST  = 8'h02
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [7:0]          off,
  input  logic [7:0]          wdata,
  output logic [N_ATTR*8-1:0] attr_q,
  output logic [7:0]          ctrl_q
);
  // one enable and one byte register per attribute offset
  for (genvar i = 0; i < N_ATTR; i++) begin : g_attr
    logic       en;
    logic [7:0] d;

    always_comb begin
      en = we && (off == ATTR_BASE + 8'(i));
      d  = en ? wdata : attr_q[i*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_q[i*8 +: 8] <= 8'h00;
      else        attr_q[i*8 +: 8] <= d;
    end
  end

  logic       ctrl_en;
  logic [7:0] ctrl_d;

  always_comb begin
    ctrl_en = we && (off == CTRL_OFF);
    ctrl_d  = ctrl_en ? wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/lmr_window_dec.sv
module lmr_window_dec #(
  parameter int ADDR_W = 32,
  parameter int N_SEG  = 12,
  parameter int N_ATTR = 7
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [N_ATTR*8-1:0] attr,
  output logic                video_hit,
  output logic                fld_hit,
  output logic [1:0]          fld
);
  localparam int SEG_IDX_W = 4;

  logic                 below_1m;
  logic                 top_hit;
  logic                 seg_hit;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic [1:0]           seg_fld [N_SEG];
  logic [1:0]           seg_sel;

  always_comb begin
    below_1m  = (addr[ADDR_W-1:20] == '0);
    video_hit = below_1m && (addr[19:17] == 3'b101);
    top_hit   = below_1m && (addr[19:16] == 4'hF);
    seg_hit   = below_1m && (addr[19:18] == 2'b11) && !top_hit;
    seg_idx   = addr[17:14];
  end

  // segment k reads its field from byte 1 + k/2, nibble chosen by k parity
  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign seg_fld[k] = attr[(1 + k/2)*8 + (k%2)*4 +: 2];
  end

  always_comb begin
    seg_sel = 2'b00;
    for (int k = 0; k < N_SEG; k++) begin
      if (seg_idx == SEG_IDX_W'(k)) seg_sel = seg_fld[k];
    end
  end

  always_comb begin
    fld_hit = top_hit || seg_hit;
    fld     = top_hit ? attr[5:4] : seg_sel;
  end

  logic attr_unused;
  assign attr_unused = ^{attr[7:6], attr[3:0], addr[13:0]};
endmodule

// File: rtl/lmr_route_sel.sv
module lmr_route_sel
  import lmr_pkg::*;
(
  input  logic       video_hit,
  input  logic       fld_hit,
  input  logic [1:0] fld,
  input  logic       wr,
  input  logic       smm,
  input  logic       open_always,
  input  logic       open_in_smm,
  output logic [1:0] route
);
  route_e sel;

  always_comb begin
    sel = ROUTE_DRAM;
    if (video_hit) begin
      sel = (open_always || (smm && open_in_smm)) ? ROUTE_DRAM : ROUTE_BUS;
    end else if (fld_hit) begin
      unique case (fld)
        ATTR_DRAM_RW: sel = ROUTE_DRAM;
        ATTR_DRAM_RO: sel = wr ? ROUTE_BUS : ROUTE_DRAM;
        default:      sel = ROUTE_BUS;
      endcase
    end
    route = sel;
  end
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router #(
  parameter int         ADDR_W    = 32,
  parameter int         N_SEG     = 12,
  parameter logic [7:0] ATTR_BASE = 8'h59,
  parameter logic [7:0] CTRL_OFF  = 8'h72,
  parameter logic [7:0] CTRL_RST  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              smm_act,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_data,
  output logic [1:0]        route
);
  localparam int N_ATTR = 1 + (N_SEG + 1) / 2;

  logic                srst_n;
  logic [N_ATTR*8-1:0] attr_q;
  logic [7:0]          ctrl_q;
  logic                video_hit;
  logic                fld_hit;
  logic [1:0]          fld;

  lmr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lmr_cfg_regs #(
    .N_ATTR    (N_ATTR),
    .ATTR_BASE (ATTR_BASE),
    .CTRL_OFF  (CTRL_OFF),
    .CTRL_RST  (CTRL_RST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .we     (cfg_we),
    .off    (cfg_off),
    .wdata  (cfg_data),
    .attr_q (attr_q),
    .ctrl_q (ctrl_q)
  );

  lmr_window_dec #(
    .ADDR_W (ADDR_W),
    .N_SEG  (N_SEG),
    .N_ATTR (N_ATTR)
  ) u_dec (
    .addr      (acc_addr),
    .attr      (attr_q),
    .video_hit (video_hit),
    .fld_hit   (fld_hit),
    .fld       (fld)
  );

  lmr_route_sel u_sel (
    .video_hit   (video_hit),
    .fld_hit     (fld_hit),
    .fld         (fld),
    .wr          (acc_wr),
    .smm         (smm_act),
    .open_always (ctrl_q[6]),
    .open_in_smm (ctrl_q[3]),
    .route       (route)
  );

  logic ctrl_unused;
  assign ctrl_unused = ^{ctrl_q[7], ctrl_q[5:4], ctrl_q[2:0]};
endmodule

// File: rtl/lmr_decode_chk.sv
module lmr_decode_chk #(
  parameter int         ADDR_W    = 32,
  parameter logic [7:0] ATTR_BASE = 8'h59,
  parameter logic [7:0] CTRL_OFF  = 8'h72
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              cfg_we,
  input logic [7:0]        cfg_off,
  input logic [7:0]        cfg_data,
  input logic [1:0]        route
);
  // writes captured before the internal reset release are discarded
  logic [2:0] arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= {arm_q[1:0], 1'b1};
  end

  logic outside, ab_hit, f_hit;
  assign outside = (addr < ADDR_W'(32'hA0000)) || (addr >= ADDR_W'(32'h100000));
  assign ab_hit  = (addr >= ADDR_W'(32'hA0000)) && (addr < ADDR_W'(32'hC0000));
  assign f_hit   = (addr >= ADDR_W'(32'hF0000)) && (addr < ADDR_W'(32'h100000));

  // R9
  p_route_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route) == 1);

  // R2
  p_outside_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> route == 2'b10);

  // R6 and R8: opening the video range takes effect the next cycle
  p_video_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q[2] && cfg_we && cfg_off == CTRL_OFF && cfg_data[6])
      |=> (!ab_hit || route == 2'b10));

  // R3 and R8: top range attribute code 3 after a write
  p_top_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q[2] && cfg_we && cfg_off == ATTR_BASE && cfg_data[5:4] == 2'b11)
      |=> (!f_hit || route == 2'b10));

  // R3 and R5: top range code 0 sends accesses to the bus
  p_top_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q[2] && cfg_we && cfg_off == ATTR_BASE && cfg_data[5:4] == 2'b00)
      |=> (!f_hit || route == 2'b01));

  logic chk_unused;
  assign chk_unused = ^{cfg_data[7], cfg_data[3:0]};
endmodule

bind legacy_mem_router lmr_decode_chk #(
  .ADDR_W    (ADDR_W),
  .ATTR_BASE (ATTR_BASE),
  .CTRL_OFF  (CTRL_OFF)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (acc_addr),
  .cfg_we   (cfg_we),
  .cfg_off  (cfg_off),
  .cfg_data (cfg_data),
  .route    (route)
);

// File: tb/legacy_mem_router_bench.sv
module legacy_mem_router_bench;
  localparam logic [1:0] DRAM = 2'b10;
  localparam logic [1:0] BUS  = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] acc_addr;
  logic        acc_wr;
  logic        smm_act;
  logic        cfg_we;
  logic [7:0]  cfg_off;
  logic [7:0]  cfg_data;
  logic [1:0]  route;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_ctrl;

  always #10 clk = ~clk;

  legacy_mem_router u_legacy_mem_router (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .smm_act(smm_act), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_data(cfg_data), .route(route)
  );

  function automatic logic [1:0] exp_route(logic [31:0] a, logic w, logic s);
    logic [1:0] f;
    logic [7:0] b;
    int seg;
    if (a < 32'hA0000 || a >= 32'h100000) return DRAM;
    if (a < 32'hC0000) return (m_ctrl[6] || (s && m_ctrl[3])) ? DRAM : BUS;
    if (a >= 32'hF0000) f = m_attr[0][5:4];
    else begin
      seg = int'((a - 32'hC0000) >> 14);
      b   = m_attr[1 + seg / 2];
      f   = (seg % 2 == 1) ? b[5:4] : b[1:0];
    end
    if (f == 2'b11) return DRAM;
    if (f == 2'b01) return w ? BUS : DRAM;
    return BUS;
  endfunction

  task automatic access(input logic [31:0] a, input logic w, input logic s,
                        input string tag);
    logic [1:0] e;
    @(negedge clk);
    acc_addr = a; acc_wr = w; smm_act = s;
    #2;
    e = exp_route(a, w, s);
    checks++;
    if (route !== e) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d smm=%0d actual=%b expected=%b",
               tag, a, w, s, route, e);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = off; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) m_attr[off - 8'h59] = data;
    if (off == 8'h72) m_ctrl = data;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    logic [7:0]  o;
    void'($urandom(32'd2024));
    rst_n = 1'b0; acc_addr = '0; acc_wr = 1'b0; smm_act = 1'b0;
    cfg_we = 1'b0; cfg_off = '0; cfg_data = '0;
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_ctrl = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state sends the whole legacy window to the bus
    access(32'hA0000, 1'b0, 1'b1, "R1");
    access(32'hB8000, 1'b1, 1'b0, "R1");
    access(32'hC0000, 1'b0, 1'b0, "R1");
    access(32'hDC000, 1'b1, 1'b1, "R1");
    access(32'hFFFF0, 1'b0, 1'b0, "R1");

    // R2: outside the window
    access(32'h00000000, 1'b0, 1'b0, "R2");
    access(32'h0009FFFF, 1'b1, 1'b1, "R2");
    access(32'h00100000, 1'b1, 1'b0, "R2");
    access(32'hFFFFFFFF, 1'b0, 1'b1, "R2");

    // R3 and R8: top range, checked in the cycle after the write
    cfg_write(8'h59, 8'h30);
    access(32'hF0000, 1'b1, 1'b0, "R3");
    access(32'hFFFFF, 1'b0, 1'b0, "R3");
    cfg_write(8'h59, 8'h10);
    access(32'hF4000, 1'b1, 1'b0, "R5");
    access(32'hF4000, 1'b0, 1'b0, "R5");

    // R4 and R5: segment nibbles, read-only versus read-write
    cfg_write(8'h5A, 8'h31);
    access(32'hC0000, 1'b0, 1'b0, "R5");
    access(32'hC3FFF, 1'b1, 1'b0, "R5");
    access(32'hC4000, 1'b1, 1'b0, "R4");
    cfg_write(8'h5F, 8'h23);
    access(32'hE8000, 1'b1, 1'b0, "R4");
    access(32'hEC000, 1'b0, 1'b0, "R5");
    access(32'hEFFFF, 1'b1, 1'b1, "R5");

    // R6 and R7: video range, mode flag acts without a clock edge
    cfg_write(8'h72, 8'h08);
    access(32'hA4000, 1'b0, 1'b0, "R6");
    access(32'hA4000, 1'b0, 1'b1, "R7");
    access(32'hBFFFF, 1'b1, 1'b0, "R7");
    cfg_write(8'h72, 8'h40);
    access(32'hB0000, 1'b1, 1'b0, "R6");
    cfg_write(8'h72, 8'h02);
    access(32'hB0000, 1'b0, 1'b1, "R6");

    // R8: writes to neighbouring offsets change nothing
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_write(8'h73, 8'hFF);
    cfg_write(8'h71, 8'hFF);
    access(32'hD0000, 1'b0, 1'b0, "R8");
    access(32'hA0000, 1'b0, 1'b1, "R8");
    access(32'hC8000, 1'b1, 1'b0, "R8");

    // random mix of writes and accesses, R9 one-hot on each result
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 4 == 0) begin
        case ($urandom % 3)
          0: o = 8'h59 + 8'($urandom % 7);
          1: o = 8'h72;
          default: o = 8'($urandom);
        endcase
        cfg_write(o, 8'($urandom));
      end
      if ($urandom % 8 == 0) a = $urandom;
      else a = 32'h9C000 + ($urandom % 32'h78000);
      access(a, 1'($urandom), 1'($urandom), "R4/R5/R6");
      checks++;
      if ($countones(route) != 1) begin
        errors++;
        $display("FAIL R9 actual=%b expected=one-hot", route);
      end
    end

    finish_run();
  end
endmodule